// File: doc/BRIEF.md
# Push-Button Debouncer with Press Pulse

This block takes the raw signal from a mechanical push-button, whose contacts chatter open and closed for tens of milliseconds after each actuation, and turns it into a clean pressed/released level plus a single system-clock pulse for every accepted press. The pulse is meant to drive a counter increment or a clock enable, so that one physical press advances downstream logic by exactly one. The button is never used as a clock.

The raw input first passes through a two-flop synchronizer. A prescaler then produces a sample strobe at a spaced rate. A settle counter advances on each strobe for which the synchronized input disagrees with the currently accepted level. It clears in any cycle where the two agree. Once the disagreement has been seen on a full window of consecutive strobes, the accepted level flips. Clock frequency, sample rate, settle length in samples and button polarity are all parameters. The defaults are a 50 MHz clock, 1 kHz sampling and a 50-sample window, which covers roughly 50 ms of bounce.

Top module: `button_debouncer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `btn_level` is 0 (released) and `press_pulse` is 0. Reset is asynchronous.
- R2: With `ACTIVE_LOW`=1, a low `btn_raw` means pressed. With `ACTIVE_LOW`=0, a high `btn_raw` means pressed. `btn_level` is 1 for pressed and 0 for released, whatever the polarity.
- R3: The settle count advances only on a sample strobe that occurs once every DIV = `CLK_FREQ_HZ`/`SAMPLE_HZ` cycles. `btn_level` changes only on an edge where a strobe is active.
- R4: After `btn_raw` moves to a new steady level, `btn_level` follows no sooner than DIV*(`SETTLE_SAMPLES`-1)+2 cycles and no later than DIV*(`SETTLE_SAMPLES`+1)+3 cycles. Two changes of `btn_level` are at least DIV*(`SETTLE_SAMPLES`-1) cycles apart.
- R5: A departure of `btn_raw` from the accepted level that lasts no more than DIV*(`SETTLE_SAMPLES`-1) cycles never changes `btn_level`.
- R6: Any cycle in which the synchronized input equals the accepted level restarts the settle count, so the window must be seen again from the start.
- R7: Each accepted transition from released to pressed gives exactly one `press_pulse`, one cycle wide, in the first cycle that `btn_level` reads 1.
- R8: An accepted transition from pressed to released gives no pulse.
- R9: A bouncing press (several short chatters followed by a steady pressed level) yields exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_raw | input | 1 | Unsynchronized contact signal from the button |
| btn_level | output | 1 | Debounced level, 1 = pressed |
| press_pulse | output | 1 | One-cycle pulse on each accepted press |

## Verification
Suppose the settle count fails to clear when the input returns to the accepted level. Chattering then adds up across bounces, and a short glitch flips `btn_level` within a few sample periods, well before the settle window has passed. If the prescaler phase or the settle comparison is off by one, the press-to-level latency moves outside its window on the first clean press. If the edge logic is wrong, the fault shows as a second pulse on release, or as a pulse that stays high for two cycles, in the same cycle the level changes. A stale synchronizer reset value shows as a spurious pulse a settle window after reset.

// File: rtl/debounce_pkg.sv
package debounce_pkg;

  typedef enum logic {
    LVL_RELEASED = 1'b0,
    LVL_PRESSED  = 1'b1
  } btn_level_e;

  // Idle (released) value of the raw pin for a given polarity.
  function automatic logic idle_pin(input bit active_low);
    return active_low ? 1'b1 : 1'b0;
  endfunction

  // Map a raw pin value to a pressed flag.
  function automatic btn_level_e pin_to_level(input logic pin, input bit active_low);
    return btn_level_e'(pin ^ active_low);
  endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sample_strobe.sv
module sample_strobe #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int W = $clog2(DIV);
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] phase;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              phase <= '0;
        else if (phase == LAST)  phase <= '0;
        else                     phase <= phase + 1'b1;
      end
      assign tick = (phase == LAST);
    end
  endgenerate
endmodule

// File: rtl/settle_filter.sv
module settle_filter
  import debounce_pkg::*;
#(
  parameter int SETTLE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  btn_level_e sampled,
  output btn_level_e level,
  output logic       accept
);
  localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  logic [CW-1:0] run;
  logic          differs;

  assign differs = (sampled != level);
  assign accept  = differs && tick && (run == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= '0;
      level <= LVL_RELEASED;
    end else begin
      if (!differs || accept) run <= '0;
      else if (tick)          run <= run + 1'b1;
      if (accept) level <= sampled;
    end
  end
endmodule

// File: rtl/press_edge.sv
module press_edge
  import debounce_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  btn_level_e next_level,
  output logic       pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= accept && (next_level == LVL_PRESSED);
  end
endmodule

// File: rtl/button_debouncer.sv
module button_debouncer
  import debounce_pkg::*;
#(
  parameter int CLK_FREQ_HZ    = 50_000_000,
  parameter int SAMPLE_HZ      = 1_000,
  parameter int SETTLE_SAMPLES = 50,
  parameter bit ACTIVE_LOW     = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_raw,
  output logic btn_level,
  output logic press_pulse
);
  localparam int DIV_CYCLES = (CLK_FREQ_HZ / SAMPLE_HZ < 1) ? 1 : CLK_FREQ_HZ / SAMPLE_HZ;

  logic       pin_sync;
  logic       sample_tick;
  logic       accept;
  btn_level_e sampled;
  btn_level_e level;

  btn_sync #(.STAGES(2), .RESET_VAL(idle_pin(ACTIVE_LOW))) u_sync (
    .clk(clk), .rst_n(rst_n), .d(btn_raw), .q(pin_sync)
  );

  assign sampled = pin_to_level(pin_sync, ACTIVE_LOW);

  sample_strobe #(.DIV(DIV_CYCLES)) u_strobe (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick)
  );

  settle_filter #(.SETTLE(SETTLE_SAMPLES)) u_filter (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .sampled(sampled),
    .level(level), .accept(accept)
  );

  press_edge u_edge (
    .clk(clk), .rst_n(rst_n), .accept(accept), .next_level(sampled),
    .pulse(press_pulse)
  );

  assign btn_level = (level == LVL_PRESSED);
endmodule

// File: rtl/button_debouncer_chk.sv
module button_debouncer_chk #(
  parameter int DIV    = 4,
  parameter int SETTLE = 4
) (
  input logic clk,
  input logic rst_n,
  input logic level,
  input logic pulse,
  input logic tick
);
  localparam int MIN_GAP = DIV * (SETTLE - 1);
  localparam int GW = $clog2(MIN_GAP + 2) + 1;

  logic [GW-1:0] gap;
  logic          seen_change;
  logic          level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= '0; seen_change <= 1'b0; level_q <= 1'b0;
    end else begin
      level_q <= level;
      if (level != level_q) begin
        gap <= '0; seen_change <= 1'b1;
      end else if (gap < GW'(MIN_GAP + 1)) begin
        gap <= gap + 1'b1;
      end
    end
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n) p_reset_quiet_r1: assert (level == 1'b0 && pulse == 1'b0);
  end

  p_level_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level) |-> $past(tick));

  p_settle_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_change && level != level_q) |-> (gap >= GW'(MIN_GAP - 1)));

  p_pulse_on_press_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(level) |-> pulse);

  p_pulse_needs_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $rose(level));

  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  p_no_release_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(level) |-> !pulse);
endmodule

bind button_debouncer button_debouncer_chk #(.DIV(DIV_CYCLES), .SETTLE(SETTLE_SAMPLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .level(btn_level), .pulse(press_pulse), .tick(sample_tick)
);

// File: tb/tb_button_debouncer.sv
module tb_button_debouncer;
  localparam int DIV = 4;
  localparam int SET = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raw_lo = 1'b1;  // active-low instance input
  logic lvl_lo, pls_lo, lvl_hi, pls_hi;
  logic raw_hi;
  int checks = 0, fails = 0, cycles = 0;
  int npl_lo = 0, npl_hi = 0;
  logic pls_lo_q = 1'b0;

  always #10 clk = ~clk;  // 50 MHz
  assign raw_hi = ~raw_lo;

  button_debouncer #(.CLK_FREQ_HZ(DIV*250), .SAMPLE_HZ(250), .SETTLE_SAMPLES(SET),
                     .ACTIVE_LOW(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .btn_raw(raw_lo), .btn_level(lvl_lo), .press_pulse(pls_lo));

  button_debouncer #(.CLK_FREQ_HZ(DIV*250), .SAMPLE_HZ(250), .SETTLE_SAMPLES(SET),
                     .ACTIVE_LOW(1'b0)) dut_hi (
    .clk(clk), .rst_n(rst_n), .btn_raw(raw_hi), .btn_level(lvl_hi), .press_pulse(pls_hi));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // pulse monitor: counts pulses and flags pulses wider than one cycle (R7)
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (pls_lo) npl_lo++;
      if (pls_hi) npl_hi++;
      if (pls_lo && pls_lo_q) begin
        fails++; checks++;
        $display("FAIL R7: pulse width 2 got 1 expected 0");
      end
    end
    pls_lo_q = pls_lo;
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
      summary();
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  // {raw pin (active-low), hold cycles, expected level, expected pulses}
  typedef struct packed { logic raw; logic [7:0] hold; logic lvl; logic [1:0] np; } vec_t;
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'd30, 1'b0, 2'd0},  // idle
    '{1'b0, 8'd6,  1'b0, 2'd0},  // R5 short press glitch
    '{1'b1, 8'd6,  1'b0, 2'd0},  // R6 return restarts
    '{1'b0, 8'd30, 1'b1, 2'd1},  // R7 clean press
    '{1'b1, 8'd5,  1'b1, 2'd0},  // R5 release glitch
    '{1'b0, 8'd30, 1'b1, 2'd0},  // held
    '{1'b1, 8'd30, 1'b0, 2'd0},  // R8 release, no pulse
    '{1'b0, 8'd3,  1'b0, 2'd0},  // R9 chatter
    '{1'b1, 8'd3,  1'b0, 2'd0},
    '{1'b0, 8'd4,  1'b0, 2'd0},
    '{1'b1, 8'd2,  1'b0, 2'd0},
    '{1'b0, 8'd30, 1'b1, 2'd1}   // R9 settles, one pulse
  };

  initial begin
    int base_lo, base_hi, n;
    // R1 reset state
    step(3);
    check("R1 level in reset", lvl_lo, 0);
    check("R1 pulse in reset", pls_lo, 0);
    rst_n = 1'b1;
    step(1);
    check("R1 level after reset", lvl_lo, 0);
    check("R2 active-high idle", lvl_hi, 0);

    for (int v = 0; v < NV; v++) begin
      base_lo = npl_lo; base_hi = npl_hi;
      raw_lo = VECS[v].raw;
      step(int'(VECS[v].hold));
      check($sformatf("R5/R7 vec %0d level", v), lvl_lo, VECS[v].lvl);
      check($sformatf("R7/R8 vec %0d pulses", v), npl_lo - base_lo, VECS[v].np);
      check($sformatf("R2 vec %0d active-high level", v), lvl_hi, VECS[v].lvl);
      check($sformatf("R2 vec %0d active-high pulses", v), npl_hi - base_hi, VECS[v].np);
    end

    // R3/R4 latency window for a clean release
    raw_lo = 1'b1; n = 0;
    while (lvl_lo && n < 100) begin step(1); n++; end
    check("R4 latency not below window", (n >= DIV*(SET-1)+2) ? 1 : 0, 1);
    check("R3 latency not above window", (n <= DIV*(SET+1)+3) ? 1 : 0, 1);
    step(20);

    // R1 reset while pressed clears level; re-press accepted once
    raw_lo = 1'b0; step(30);
    check("R1 pressed before reset", lvl_lo, 1);
    rst_n = 1'b0; #2;
    check("R1 async clear", lvl_lo, 0);
    step(2);
    base_lo = npl_lo;
    rst_n = 1'b1;
    step(1);
    check("R1 level first cycle", lvl_lo, 0);
    step(30);
    check("R4 re-accept after reset", lvl_lo, 1);
    check("R7 one pulse after reset", npl_lo - base_lo, 1);

    summary();
  end
endmodule